// File: doc/BRIEF.md
# Hub interrupt status-change reporter

This block produces the payload side of a hub's interrupt endpoint. It watches one change flag for the hub itself and one for each downstream port. Once per frame, on the end-of-frame marker, it folds those flags into a sticky change bitmap. The bitmap is ready for the host to poll in the following frame.

When an IN token reaches the endpoint, the block decides between a one-byte data answer and a NAK. It then holds that decision and the byte steady until the surrounding packet logic reports that the response has gone out. A bit stays in the bitmap until a clear strobe for that source removes it. While the hub is unconfigured every poll gets a NAK, but the bitmap keeps collecting changes so they can be reported once configuration is done. Packet encoding, CRC and handshake timing belong to the neighbouring logic.

Top module: `hub_chg_reporter`

## Requirements
- R1: The response byte carries the hub change in bit 0 and the change of port k (k = 1..4) in bit k; bits 7 to 5 always read 0.
- R2: A change flag enters the bitmap only in a cycle where `eof_i` is 1; a flag raised and polled with no marker in between gives a NAK.
- R3: An accepted IN token with an empty bitmap yields `rsp_data_o` = 0 (NAK) with `rsp_byte_o` = 0.
- R4: An accepted IN token with a non-empty bitmap while configured yields `rsp_data_o` = 1 and the whole bitmap byte on `rsp_byte_o`.
- R5: A latched bit is reported on every poll, and later markers do not remove it, even after its source flag has dropped.
- R6: A pulse on `clr_i[n]` removes bit n only. If a marker arrives in the same cycle while source n is still flagged, bit n stays set.
- R7: While `configured_i` is 0 every accepted token gets a NAK, and sampling continues. Changes collected then are reported on the first poll after configuration.
- R8: From acceptance until the cycle after `rsp_done_i`, `rsp_byte_o` and `rsp_data_o` do not change, and further IN tokens are ignored, even if markers or clears arrive meanwhile.
- R9: After reset `rsp_busy_o`, `rsp_data_o` and `rsp_byte_o` are 0 and the bitmap is empty.
- R10: An IN token while idle is accepted at the next clock edge: `rsp_busy_o` is 1 in the following cycle. The answer reflects the bitmap as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hub_chg_i | input | 1 | Hub-level change flag |
| port_chg_i | input | 4 | Per-port change flags, bit 0 is port 1 |
| clr_i | input | 5 | Clear strobes, bit 0 hub, bit k port k |
| configured_i | input | 1 | Hub has been configured by the host |
| eof_i | input | 1 | End-of-frame sampling marker |
| in_tok_i | input | 1 | IN token addressed to the endpoint |
| rsp_done_i | input | 1 | Response has been sent |
| rsp_busy_o | output | 1 | A response is being held |
| rsp_data_o | output | 1 | 1 = send data byte, 0 = NAK |
| rsp_byte_o | output | 8 | Status-change byte |

## Verification
On every cycle, the assertions check four things: the reserved bits stay zero, a NAK never carries a non-zero byte, a data answer never carries an empty one, and the held answer stays frozen while busy. They also check token acceptance, release on completion, and the NAK for tokens taken while unconfigured. Only the bench's scenarios can show the rest. That covers sampling confined to the marker, bits surviving later frames, and clear-versus-sample priority in a shared cycle. It also covers changes collected before configuration reappearing afterwards, and clears arriving during a held answer showing only in the next poll.

// File: rtl/hub_chg_reporter.sv
module hub_chg_reporter #(
  parameter int NPORT  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hub_chg_i,
  input  logic [NPORT-1:0]  port_chg_i,
  input  logic [NPORT:0]    clr_i,
  input  logic              configured_i,
  input  logic              eof_i,
  input  logic              in_tok_i,
  input  logic              rsp_done_i,
  output logic              rsp_busy_o,
  output logic              rsp_data_o,
  output logic [BYTE_W-1:0] rsp_byte_o
);
  localparam int NSRC = NPORT + 1;

  logic [NSRC-1:0]   chg_q;
  logic [NSRC-1:0]   kept;
  logic [NSRC-1:0]   chg_d;
  logic              grant;
  logic              busy_q;
  logic              data_q;
  logic [BYTE_W-1:0] byte_q;

  assign kept  = chg_q & ~clr_i;
  assign chg_d = eof_i ? (kept | {port_chg_i, hub_chg_i}) : kept;
  assign grant = configured_i & (|chg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      data_q <= 1'b0;
      byte_q <= '0;
    end else if (busy_q) begin
      if (rsp_done_i) busy_q <= 1'b0;
    end else if (in_tok_i) begin
      busy_q <= 1'b1;
      data_q <= grant;
      byte_q <= grant ? BYTE_W'(chg_q) : '0;
    end
  end

  assign rsp_busy_o = busy_q;
  assign rsp_data_o = data_q;
  assign rsp_byte_o = byte_q;
endmodule

// File: rtl/hub_chg_reporter_chk.sv
module hub_chg_reporter_chk #(
  parameter int NPORT  = 4,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              configured_i,
  input logic              in_tok_i,
  input logic              rsp_done_i,
  input logic              rsp_busy_o,
  input logic              rsp_data_o,
  input logic [BYTE_W-1:0] rsp_byte_o
);
  localparam int NSRC = NPORT + 1;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_byte_o >> NSRC) == '0);

  p_nak_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_data_o |-> rsp_byte_o == '0);

  p_data_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_data_o |-> rsp_byte_o != '0);

  p_unconf_nak_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_busy_o) && !$past(configured_i) |-> !rsp_data_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_busy_o && $past(rsp_busy_o) |-> $stable(rsp_byte_o) && $stable(rsp_data_o));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_busy_o && rsp_done_i |=> !rsp_busy_o);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok_i && !rsp_busy_o |=> rsp_busy_o);
endmodule

bind hub_chg_reporter hub_chg_reporter_chk #(.NPORT(NPORT), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .configured_i(configured_i), .in_tok_i(in_tok_i),
  .rsp_done_i(rsp_done_i), .rsp_busy_o(rsp_busy_o), .rsp_data_o(rsp_data_o),
  .rsp_byte_o(rsp_byte_o)
);

// File: tb/hub_chg_reporter_tb_top.sv
`timescale 1ns/1ps
module hub_chg_reporter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hub_chg = 1'b0;
  logic [3:0] port_chg = '0;
  logic [4:0] clr = '0;
  logic cfg = 1'b0, eof = 1'b0, tok = 1'b0, done = 1'b0;
  logic busy, data;
  logic [7:0] byte_o;

  int checks = 0, failures = 0;
  int m_bits = 0, m_busy = 0, m_data = 0, m_byte = 0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  hub_chg_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .hub_chg_i(hub_chg), .port_chg_i(port_chg),
    .clr_i(clr), .configured_i(cfg), .eof_i(eof), .in_tok_i(tok),
    .rsp_done_i(done), .rsp_busy_o(busy), .rsp_data_o(data), .rsp_byte_o(byte_o)
  );

  task automatic model_update();
    int old;
    old = m_bits;
    if (!rst_n) begin
      m_bits = 0; m_busy = 0; m_data = 0; m_byte = 0;
    end else begin
      if (m_busy != 0) begin
        if (done) m_busy = 0;
      end else if (tok) begin
        m_busy = 1;
        m_data = (cfg && old != 0) ? 1 : 0;
        m_byte = (m_data != 0) ? old : 0;
      end
      m_bits = old & ~int'(clr) & 31;
      if (eof) m_bits = m_bits | int'({port_chg, hub_chg});
    end
  endtask

  task automatic compare();
    checks++;
    if (int'(busy) != m_busy || int'(data) != m_data || int'(byte_o) != m_byte) begin
      failures++;
      $display("FAIL model %s act busy=%0b data=%0b byte=%02h exp busy=%0d data=%0d byte=%02h",
               cur_req, busy, data, byte_o, m_busy, m_data, m_byte);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic frame_mark();
    eof = 1'b1; step(); eof = 1'b0;
  endtask

  task automatic poll(string req, int exp_data, int exp_byte);
    tok = 1'b1; step(); tok = 1'b0;
    expect_eq({req, " busy"}, int'(busy), 1);
    expect_eq({req, " kind"}, int'(data), exp_data);
    expect_eq({req, " byte"}, int'(byte_o), exp_byte);
    done = 1'b1; step(); done = 1'b0;
    expect_eq({req, " release"}, int'(busy), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    cur_req = "R9";
    expect_eq("R9 busy", int'(busy), 0);
    expect_eq("R9 byte", int'(byte_o), 0);
    rst_n = 1'b1;
    step();
    poll("R9 empty after reset", 0, 8'h00);

    cur_req = "R7";
    port_chg = 4'b0010;
    frame_mark();
    port_chg = '0;
    poll("R7 unconfigured NAK", 0, 8'h00);
    cfg = 1'b1; step();
    poll("R7 reported after config", 1, 8'h04);

    cur_req = "R5";
    frame_mark();
    poll("R5 sticky across frame", 1, 8'h04);

    cur_req = "R6";
    clr = 5'b00100; step(); clr = '0;
    poll("R3 empty after clear", 0, 8'h00);

    cur_req = "R2";
    hub_chg = 1'b1; step();
    poll("R2 no sample without marker", 0, 8'h00);
    frame_mark();
    poll("R4 hub bit data", 1, 8'h01);

    cur_req = "R6";
    clr = 5'b00001; eof = 1'b1; step(); clr = '0; eof = 1'b0;
    poll("R6 sample wins over clear", 1, 8'h01);
    hub_chg = 1'b0;
    clr = 5'b00001; step(); clr = '0;
    poll("R6 clear removes bit", 0, 8'h00);

    cur_req = "R1";
    hub_chg = 1'b1; port_chg = 4'hF;
    frame_mark();
    hub_chg = 1'b0; port_chg = '0;
    poll("R1 all sources, reserved zero", 1, 8'h1F);

    cur_req = "R8";
    tok = 1'b1; step(); tok = 1'b0;
    expect_eq("R10 accepted next cycle", int'(busy), 1);
    clr = 5'b01000; step(); clr = '0;
    port_chg = 4'b1000; frame_mark(); port_chg = '0;
    tok = 1'b1; step(); tok = 1'b0;
    expect_eq("R8 byte held", int'(byte_o), 8'h1F);
    expect_eq("R8 still busy", int'(busy), 1);
    done = 1'b1; step(); done = 1'b0;
    clr = 5'b01000; step(); clr = '0;
    poll("R8 clear shows next poll", 1, 8'h17);

    cur_req = "R3";
    clr = 5'b11111; step(); clr = '0;
    poll("R3 NAK when empty", 0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule